// File: doc/BRIEF.md
# Cable-Test Reflectometry Sequencer

This block controls one cable-diagnostic measurement on a single-pair Ethernet port. A write with the start bit set launches three timed phases. The first is a quiet period before transmission. The second is a modulated transmit window whose length is programmed in microseconds. The third is a quiet period after transmission. When the third phase ends, the port drops into a forced-link state. The block times every phase with a microsecond tick supplied by the surrounding logic. While the transmit window is open it drives a transmit-enable and an amplitude select to the analog front end.

When the transmit window closes, the block captures the peak-search result from the correlator into a fault word: detect flag, sign and a 10-bit location. It then reports completion. If a link partner shows activity during the quiet period before transmission, the measurement is aborted and reported as failed. In that case the fault result is not captured. A soft-reset request aborts any phase and clears the status.

Top module: `cable_diag_seq`

## Requirements
- R1: After a synchronous active-low reset, `tx_en`, `tx_amp_hi` and `force_link` are 0, and `ctl_rdata` and `flt_word` read 0.
- R2: The control word bits are as follows. Bit 15 written as 1 (with bit 14 at 0) starts a measurement from idle or from the forced-link state, and bits 1 and 0 then read 0. Bit 15 of `ctl_rdata` reads 1 while a measurement runs. Bit 1 is done and bit 0 is fail.
- R3: The quiet-time selects use the codes 0, 1, 2 and 3, which mean 0, 10, 100 and 1000 ms. One ms is `TICKS_PER_MS` ticks. A phase of N ticks lasts from its first cycle until the cycle after its N-th tick. A zero-length phase therefore lasts one clock.
- R4: `tx_en` is high only in the transmit phase. `tx_amp_hi` equals the amplitude select latched at start (0 = 1 V, 1 = 2.4 V) during transmission and is 0 otherwise.
- R5: The phases run in a fixed order: pre-quiet, transmit, post-quiet, then forced link. On entry to forced link, done reads 1 and fail reads 0, and `force_link` stays high until the next start or soft reset.
- R6: When the transmit phase ends, `flt_word` captures bit 11 = peak detected, bit 10 = peak sign and bits 9:0 = location, with bits 15:12 at 0. It is cleared by start and by soft reset and holds otherwise.
- R7: `link_act` high during pre-quiet ends the measurement at the next edge. The block returns to idle with done and fail both 1, transmission never starts, and the fault word stays 0.
- R8: A start write while a measurement runs is ignored, and the running phases keep their timing.
- R9: Bit 14 of the control write aborts any phase in the next cycle. It returns to idle and clears done, fail, the fault word, `tx_en` and `force_link`. It has priority over bit 15.
- R10: The transmit duration register is 16 bits with a reset value of 16000 µs. A write takes effect at the next entry into the transmit phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 2 | Control write bits 15 (start) and 14 (soft reset) |
| pre_sel | input | 2 | Pre-quiet length code, sampled at start |
| post_sel | input | 2 | Post-quiet length code, latched at start |
| amp_sel | input | 1 | Transmit amplitude select, latched at start |
| dur_we | input | 1 | Transmit duration write strobe |
| dur_wdata | input | 16 | Transmit duration in µs |
| link_act | input | 1 | Link-partner activity seen on the line |
| pk_detect | input | 1 | Peak found by correlator |
| pk_sign | input | 1 | Sign of the peak |
| pk_loc | input | 10 | Peak location |
| tx_en | output | 1 | Modulated transmit enable |
| tx_amp_hi | output | 1 | High-amplitude transmit select |
| force_link | output | 1 | Forced-link mode after the sequence |
| ctl_rdata | output | 16 | Status: bit 15 busy, bit 1 done, bit 0 fail |
| flt_word | output | 16 | Captured fault result |

## Verification
All outputs are registered state, so a control write or a `link_act` pulse shows its effect one clock after the edge that samples it. A phase boundary appears one clock after the edge on which the phase counter is already zero. With a tick in every cycle, a phase of N ticks is therefore visible for N+1 cycles. The bench drives inputs and samples outputs on the falling edge and advances its behavioural model on the rising edge, so each comparison lands in the cycle where the result is due. Phase lengths are also counted directly against those N+1 figures for several codes and durations, and one run uses a sparse tick to confirm that only ticks advance the timers.

// File: rtl/cdiag_pkg.sv
// Shared types for the cable-diagnostic sequencer.
// Assumes: quiet-time codes map to 0/10/100/1000 ms.
package cdiag_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_TX,
        PH_POST,
        PH_LINK
    } cdiag_phase_e;

    // Milliseconds selected by a 2-bit quiet-time code.
    function automatic int quiet_ms(input logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 10;
            2'd2:    return 100;
            default: return 1000;
        endcase
    endfunction

endpackage

// File: rtl/cdiag_phase_timer.sv
// Phase timer: loads a tick count and counts it down on each tick.
// Assumes: the load has priority over a tick in the same cycle; expired
// is high whenever the count is zero.
module cdiag_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load the phase length, or count down one tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/cdiag_dur_reg.sv
// Transmit-duration holding register with a programmable reset value.
// Assumes: writes are single-cycle strobes.
module cdiag_dur_reg #(
    parameter int          W   = 16,
    parameter logic [W-1:0] DEF = 16'd16000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Hold the programmed duration, starting from its reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= DEF;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/cdiag_fault_cap.sv
// Fault-result capture: packs detect, sign and location into a status word.
// Assumes: bit 11 detect, bit 10 sign, low LOC_W bits location.
module cdiag_fault_cap #(
    parameter int LOC_W = 10,
    parameter int WRD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cap,
    input  logic             pk_detect,
    input  logic             pk_sign,
    input  logic [LOC_W-1:0] pk_loc,
    output logic [WRD_W-1:0] word
);

    localparam int PAD_W = WRD_W - LOC_W - 2;

    // Clear on request, capture at the end of transmission, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word <= '0;
        end else if (cap) begin
            word <= {{PAD_W{1'b0}}, pk_detect, pk_sign, pk_loc};
        end
    end

endmodule

// File: rtl/cable_diag_seq.sv
// Cable-test sequencer top. Runs the pre-quiet, transmit and post-quiet
// phases, then enters forced link. Reports busy, done and fail, and holds
// the captured fault word.
// Assumes: us_tick is a single-cycle pulse; the peak result inputs are
// valid in the last cycle of the transmit phase.
module cable_diag_seq
    import cdiag_pkg::*;
#(
    parameter int           TICKS_PER_MS = 1000,
    parameter int           DUR_W        = 16,
    parameter logic [15:0]  DUR_DEF      = 16'd16000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             ctl_we,
    input  logic [15:14]     ctl_wdata,
    input  logic [1:0]       pre_sel,
    input  logic [1:0]       post_sel,
    input  logic             amp_sel,
    input  logic             dur_we,
    input  logic [DUR_W-1:0] dur_wdata,
    input  logic             link_act,
    input  logic             pk_detect,
    input  logic             pk_sign,
    input  logic [9:0]       pk_loc,
    output logic             tx_en,
    output logic             tx_amp_hi,
    output logic             force_link,
    output logic [15:0]      ctl_rdata,
    output logic [15:0]      flt_word
);

    localparam int LOC_W   = 10;
    localparam int SIL_MAX = 1000 * TICKS_PER_MS;
    localparam int SIL_W   = $clog2(SIL_MAX + 1);
    localparam int CNT_W   = (SIL_W > DUR_W) ? SIL_W : DUR_W;

    cdiag_phase_e     st_q, st_d;
    logic             done_q, fail_q, amp_q;
    logic [1:0]       post_q;
    logic             start_req, srst_req, busy;
    logic             ld, expired, cap, clr, set_done, set_fail, latch_cfg;
    logic [CNT_W-1:0] ld_val;
    logic [DUR_W-1:0] dur_q;

    // Ticks for a quiet-time code.
    function automatic logic [CNT_W-1:0] quiet_ticks(input logic [1:0] code);
        return CNT_W'(quiet_ms(code) * TICKS_PER_MS);
    endfunction

    assign start_req = ctl_we && ctl_wdata[15];
    assign srst_req  = ctl_we && ctl_wdata[14];
    assign busy      = (st_q == PH_PRE) || (st_q == PH_TX) || (st_q == PH_POST);

    cdiag_dur_reg #(.W(DUR_W), .DEF(DUR_W'(DUR_DEF))) u_dur (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dur_we),
        .wdata (dur_wdata),
        .q     (dur_q)
    );

    cdiag_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    cdiag_fault_cap #(.LOC_W(LOC_W), .WRD_W(16)) u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .cap       (cap),
        .pk_detect (pk_detect),
        .pk_sign   (pk_sign),
        .pk_loc    (pk_loc),
        .word      (flt_word)
    );

    // Phase sequencing: choose the next phase and the timer and status actions.
    always_comb begin
        st_d      = st_q;
        ld        = 1'b0;
        ld_val    = '0;
        cap       = 1'b0;
        clr       = 1'b0;
        set_done  = 1'b0;
        set_fail  = 1'b0;
        latch_cfg = 1'b0;
        if (srst_req) begin
            st_d = PH_IDLE;
            clr  = 1'b1;
        end else begin
            case (st_q)
                PH_IDLE, PH_LINK: begin
                    if (start_req) begin
                        st_d      = PH_PRE;
                        ld        = 1'b1;
                        ld_val    = quiet_ticks(pre_sel);
                        clr       = 1'b1;
                        latch_cfg = 1'b1;
                    end
                end
                PH_PRE: begin
                    if (link_act) begin
                        st_d     = PH_IDLE;
                        set_done = 1'b1;
                        set_fail = 1'b1;
                    end else if (expired) begin
                        st_d   = PH_TX;
                        ld     = 1'b1;
                        ld_val = CNT_W'(dur_q);
                    end
                end
                PH_TX: begin
                    if (expired) begin
                        st_d   = PH_POST;
                        ld     = 1'b1;
                        ld_val = quiet_ticks(post_q);
                        cap    = 1'b1;
                    end
                end
                PH_POST: begin
                    if (expired) begin
                        st_d     = PH_LINK;
                        set_done = 1'b1;
                    end
                end
                default: st_d = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PH_IDLE;
        else        st_q <= st_d;
    end

    // Done and fail flags: cleared on start or soft reset, set at phase exits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (set_done) done_q <= 1'b1;
            if (set_fail) fail_q <= 1'b1;
        end
    end

    // Latch the amplitude and post-quiet code at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amp_q  <= 1'b0;
            post_q <= 2'd0;
        end else if (latch_cfg) begin
            amp_q  <= amp_sel;
            post_q <= post_sel;
        end
    end

    assign tx_en      = (st_q == PH_TX);
    assign tx_amp_hi  = tx_en && amp_q;
    assign force_link = (st_q == PH_LINK);
    assign ctl_rdata  = {busy, 13'd0, done_q, fail_q};

endmodule

// File: rtl/cable_diag_seq_chk.sv
// Property checker for the cable-test sequencer, bound to the top.
// Assumes: the port names of cable_diag_seq.
module cable_diag_seq_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         ctl_we,
    input logic [15:14] ctl_wdata,
    input logic         tx_en,
    input logic         tx_amp_hi,
    input logic         force_link,
    input logic [15:0]  ctl_rdata,
    input logic [15:0]  flt_word
);

    // R4
    tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (!force_link && ctl_rdata[15]));

    // R4
    amp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !tx_amp_hi);

    // R7
    fail_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[0] |-> ctl_rdata[1]);

    // R9
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[14]) |=>
        (ctl_rdata == 16'h0 && !tx_en && !force_link && flt_word == 16'h0));

    // R6
    flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !ctl_we) |=> $stable(flt_word));

    // R5
    link_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_link) |-> (ctl_rdata[1] && !ctl_rdata[0]));

    // R2
    start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[15] && !ctl_wdata[14] && !ctl_rdata[15]) |=>
        (ctl_rdata[15] && ctl_rdata[1:0] == 2'b00));

endmodule

bind cable_diag_seq cable_diag_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .tx_en      (tx_en),
    .tx_amp_hi  (tx_amp_hi),
    .force_link (force_link),
    .ctl_rdata  (ctl_rdata),
    .flt_word   (flt_word)
);

// File: tb/sim_cable_diag_seq.sv
// Bench for the cable-test sequencer: behavioural model compared every cycle
// plus direct phase-length and status checks.
module sim_cable_diag_seq;

    localparam int TPM = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        ctl_we = 1'b0;
    logic [15:14] ctl_wdata = 2'b00;
    logic [1:0]  pre_sel = 2'd0;
    logic [1:0]  post_sel = 2'd0;
    logic        amp_sel = 1'b0;
    logic        dur_we = 1'b0;
    logic [15:0] dur_wdata = 16'd0;
    logic        link_act = 1'b0;
    logic        pk_detect = 1'b0;
    logic        pk_sign = 1'b0;
    logic [9:0]  pk_loc = 10'd0;
    logic        tx_en, tx_amp_hi, force_link;
    logic [15:0] ctl_rdata, flt_word;

    int n_chk = 0;
    int n_err = 0;
    int tick_div = 1;
    int tick_ct = 0;
    logic cmp_on = 1'b0;

    // Model state.
    int m_ph = 0, m_left = 0, m_post = 0, m_dur = 16000;
    logic m_done = 0, m_fail = 0, m_amp = 0;
    logic [15:0] m_flt = 16'h0;

    always #10 clk = ~clk;

    cable_diag_seq #(.TICKS_PER_MS(TPM)) u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .pre_sel(pre_sel), .post_sel(post_sel),
        .amp_sel(amp_sel), .dur_we(dur_we), .dur_wdata(dur_wdata),
        .link_act(link_act), .pk_detect(pk_detect), .pk_sign(pk_sign),
        .pk_loc(pk_loc), .tx_en(tx_en), .tx_amp_hi(tx_amp_hi),
        .force_link(force_link), .ctl_rdata(ctl_rdata), .flt_word(flt_word)
    );

    function automatic int qticks(input logic [1:0] c);
        case (c)
            2'd0: return 0;
            2'd1: return 10 * TPM;
            2'd2: return 100 * TPM;
            default: return 1000 * TPM;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Microsecond tick source, one pulse every tick_div cycles.
    always @(negedge clk) begin
        us_tick <= ((tick_ct % tick_div) == 0);
        tick_ct <= tick_ct + 1;
    end

    // Behavioural model advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_post = 0; m_dur = 16000;
            m_done = 0; m_fail = 0; m_amp = 0; m_flt = 16'h0;
        end else begin
            if (ctl_we && ctl_wdata[14]) begin
                m_ph = 0; m_done = 0; m_fail = 0; m_flt = 16'h0;
            end else begin
                case (m_ph)
                    0, 4: if (ctl_we && ctl_wdata[15]) begin
                        m_ph = 1; m_left = qticks(pre_sel); m_post = qticks(post_sel);
                        m_amp = amp_sel; m_done = 0; m_fail = 0; m_flt = 16'h0;
                    end
                    1: if (link_act) begin
                        m_ph = 0; m_done = 1; m_fail = 1;
                    end else if (m_left == 0) begin
                        m_ph = 2; m_left = m_dur;
                    end else if (us_tick) m_left--;
                    2: if (m_left == 0) begin
                        m_ph = 3; m_left = m_post;
                        m_flt = {4'h0, pk_detect, pk_sign, pk_loc};
                    end else if (us_tick) m_left--;
                    3: if (m_left == 0) begin
                        m_ph = 4; m_done = 1;
                    end else if (us_tick) m_left--;
                    default: m_ph = 0;
                endcase
            end
            if (dur_we) m_dur = int'(dur_wdata);
        end
    end

    // Every-cycle comparison against the model, on the falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R4 tx_en", int'(tx_en), int'(m_ph == 2));
            check("R4 tx_amp_hi", int'(tx_amp_hi), int'(m_ph == 2 && m_amp));
            check("R5 force_link", int'(force_link), int'(m_ph == 4));
            check("R2/R7/R9 status", int'(ctl_rdata),
                  int'({(m_ph >= 1 && m_ph <= 3), 13'd0, m_done, m_fail}));
            check("R6 fault word", int'(flt_word), int'(m_flt));
        end
    end

    task automatic wr_ctl(input logic [15:14] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = 2'b00;
    endtask

    task automatic wr_dur(input logic [15:0] v);
        dur_we = 1'b1; dur_wdata = v;
        @(negedge clk);
        dur_we = 1'b0;
    endtask

    task automatic do_run(input logic [1:0] pr, input logic [1:0] po, input logic am,
                          output int npre, output int ntx, output int npost,
                          output logic amp_ok);
        npre = 0; ntx = 0; npost = 0; amp_ok = 1'b1;
        pre_sel = pr; post_sel = po; amp_sel = am;
        wr_ctl(2'b10);
        for (int i = 0; i < 100000; i++) begin
            if (!ctl_rdata[15]) break;
            if (tx_en) begin
                ntx++;
                if (tx_amp_hi !== am) amp_ok = 1'b0;
            end else if (ntx == 0) npre++;
            else npost++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
        $finish;
    end

    initial begin
        int a, b, c, nb;
        logic ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_en", int'(tx_en), 0);
        check("R1 force_link", int'(force_link), 0);
        check("R1 status", int'(ctl_rdata), 0);
        check("R1 fault word", int'(flt_word), 0);
        cmp_on = 1'b1;

        // R10 default duration, R3 zero-length quiet, R5 order, R6 capture
        pk_detect = 1'b1; pk_sign = 1'b0; pk_loc = 10'h155;
        do_run(2'd0, 2'd0, 1'b0, a, b, c, ok);
        check("R3 zero pre-quiet cycles", a, 1);
        check("R10 default tx cycles", b, 16001);
        check("R3 zero post-quiet cycles", c, 1);
        check("R5 forced link", int'(force_link), 1);
        check("R5 done status", int'(ctl_rdata), 16'h0002);
        check("R6 fault word", int'(flt_word), 16'h0955);

        // R10 new duration, R3 codes 1 and 2, R4 high amplitude
        wr_dur(16'd40);
        pk_detect = 1'b0; pk_sign = 1'b1; pk_loc = 10'h2AB;
        do_run(2'd1, 2'd2, 1'b1, a, b, c, ok);
        check("R3 pre code 1 cycles", a, 10 * TPM + 1);
        check("R10 tx cycles after write", b, 41);
        check("R3 post code 2 cycles", c, 100 * TPM + 1);
        check("R4 amplitude during tx", int'(ok), 1);
        check("R6 fault word sign only", int'(flt_word), 16'h06AB);

        // R3 code 3
        do_run(2'd3, 2'd0, 1'b0, a, b, c, ok);
        check("R3 pre code 3 cycles", a, 1000 * TPM + 1);
        check("R4 amplitude low", int'(ok), 1);

        // R3 sparse ticks: model comparison covers timing
        tick_div = 3;
        do_run(2'd1, 2'd1, 1'b0, a, b, c, ok);
        check("R3 sparse tick done", int'(ctl_rdata), 16'h0002);
        tick_div = 1;
        @(negedge clk);

        // R8 start during transmit ignored
        pre_sel = 2'd0; post_sel = 2'd0;
        wr_ctl(2'b10);
        nb = 0;
        for (int i = 0; i < 1000; i++) begin
            if (!ctl_rdata[15]) break;
            nb++;
            ctl_we = (i == 10); ctl_wdata = (i == 10) ? 2'b10 : 2'b00;
            @(negedge clk);
        end
        ctl_we = 1'b0; ctl_wdata = 2'b00;
        check("R8 busy cycles unchanged", nb, 43);

        // R7 link activity during pre-quiet
        pre_sel = 2'd3;
        wr_ctl(2'b10);
        repeat (5) @(negedge clk);
        link_act = 1'b1;
        @(negedge clk);
        link_act = 1'b0;
        check("R7 done+fail", int'(ctl_rdata), 16'h0003);
        check("R7 no tx", int'(tx_en), 0);
        check("R7 fault word empty", int'(flt_word), 0);
        repeat (2) @(negedge clk);
        check("R7 status sticky", int'(ctl_rdata), 16'h0003);

        // R9 soft reset during transmit
        pre_sel = 2'd0; pk_detect = 1'b1;
        wr_ctl(2'b10);
        repeat (10) @(negedge clk);
        check("R9 in tx before abort", int'(tx_en), 1);
        wr_ctl(2'b01);
        check("R9 tx off", int'(tx_en), 0);
        check("R9 status cleared", int'(ctl_rdata), 0);

        // R9 soft reset from forced link, with priority over start
        do_run(2'd0, 2'd0, 1'b0, a, b, c, ok);
        check("R9 precondition link", int'(force_link), 1);
        wr_ctl(2'b11);
        check("R9 link cleared", int'(force_link), 0);
        check("R9 status after abort", int'(ctl_rdata), 0);
        check("R9 fault cleared", int'(flt_word), 0);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule